// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block drives a byte-wide NOR flash from the host side. A client hands it one request at a time over a valid/ready handshake. The request is a single-byte program, an erase of a set of sectors, or an erase of the whole array. The block then issues the unlock and command writes on a simple synchronous memory bus. Next it polls status reads until the flash reports completion or an error. It finishes with a one-cycle done pulse that carries a pass flag.

Each bus access on the memory side takes one cycle. A read returns its byte on `mem_rdata_i` in the cycle after the strobe. Completion can be judged in two ways. The first watches bit 7 against the value expected. The second watches whether bit 6 stops alternating between consecutive reads. Bit 5 reports that the flash exceeded its time limit, and this always triggers one more read before a failure is declared. A sector-erase request may name several sectors. The first sector goes into the six-write command. Each further sector is added with its own command write, and bit 3 is read just before and just after that write. If either read shows the erase timer already closed, a warning flag is raised. Any failure is followed by the reset command sequence.

Top module: `flash_seq`

## Requirements
- R1: A program request (op 2'b00) issues exactly these writes: AAh@5555h, 55h@2AAAh, A0h@5555h, then the request byte at the request address.
- R2: In bit-7 mode (toggle select 0), status reads are made at the poll address, which is the target address for program. The operation passes on the first read whose bit 7 equals the expected bit 7. For program the expected bit 7 is data bit 7; for either erase it is 1.
- R3: In bit-7 mode, a read with bit 7 mismatched and bit 5 = 1 causes exactly one more read. That read passes if bit 7 now matches and fails otherwise.
- R4: With toggle select 1, the operation passes when bit 6 of two consecutive status reads is equal. If bit 6 differs and bit 5 = 1, one more read is made; it passes only if its bit 6 equals the one before.
- R5: A sector-erase request (op 2'b01, sector mask `req_sect_i`, sector s starting at address s·2^(AW-SECT_BITS)) issues AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at the base of the lowest set sector. It then polls at that base.
- R6: Each further sector in the mask is taken in ascending order. The block reads at the poll address, writes 30h to that sector's base, and reads again. `warn_o` is 1 at done if bit 3 was 1 in any of these reads.
- R7: A chip-erase request (op 2'b10) issues the same five writes as R5 followed by 10h@5555h, then polls at the request address.
- R8: After any failure, the block writes AAh@5555h, 55h@2AAAh, F0h@5555h before done, and reports pass_o = 0.
- R9: For either erase with `req_blank_i` = 1, a passing poll is followed by one read at the poll address. The request passes only if that read returns FFh.
- R10: After POLL_LIMIT consecutive unsettled status reads without any bit-5 recheck, the request fails.
- R11: `req_ready_o` is 1 only when idle. After acceptance it stays 0 until the single-cycle done pulse, and it is 1 again in the next cycle. Request inputs presented while busy have no effect.
- R12: Out of reset the block is idle with `req_ready_o` = 1, `done_o` = 0 and no bus strobe.
- R13: A sector erase with an empty mask, or op 2'b11, makes no bus access and ends with done and pass_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready for a request (idle) |
| req_op_i | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 refused |
| req_addr_i | input | AW | Program target / chip-erase poll address |
| req_data_i | input | 8 | Byte to program |
| req_sect_i | input | 2^SECT_BITS | Sectors to erase |
| req_toggle_i | input | 1 | 1: bit-6 toggle completion check, 0: bit-7 check |
| req_blank_i | input | 1 | Check for FFh after erase |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Request succeeded, valid with done |
| warn_o | output | 1 | An added sector may not have been taken |
| mem_en_o | output | 1 | Bus access strobe |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Bus address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read strobe |

## Verification
The bench places a behavioural flash behind the bus. It records every write and read address and answers reads from a small script: a number of busy reads, the cycle at which bit 5 rises, a bit-3 pattern and a final byte. A sweep of program data values with both states of bit 7 checks the exact write list and read count. This separates a correct bit-7 compare from one that is inverted or fixed. Scripts for early bit 5, a stuck status byte and an alternating bit 6 separate the pass, recheck, timeout and reset paths. The number of reads in each case shows whether a check fired one read early or late. Sector masks with one bit set and with scattered bits, each with clear and with set bit 3, exercise sector ordering and the warning. Empty and reserved requests, and requests presented while busy, show that nothing reaches the bus.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'b00, OP_SECT = 2'b01, OP_CHIP = 2'b10, OP_RSVD = 2'b11} op_e;
  typedef enum logic [1:0] {SEQ_PROG, SEQ_SECT, SEQ_CHIP, SEQ_RST} seq_e;
  typedef enum logic [1:0] {V_CONT, V_PASS, V_FAIL, V_RECHK} verdict_e;

  localparam logic [15:0] ADR_UNLK_A = 16'h5555;
  localparam logic [15:0] ADR_UNLK_B = 16'h2AAA;
  localparam logic [7:0]  CMD_KEY_A  = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B  = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_SETUP  = 8'h80;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_RESET  = 8'hF0;
  localparam logic [7:0]  BLANK_BYTE = 8'hFF;

  localparam int B_POLL = 7;
  localparam int B_TOG  = 6;
  localparam int B_ERR  = 5;
  localparam int B_TMR  = 3;
endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_pkg::*;
#(
  parameter int AW = 17
) (
  input  seq_e          seq_i,
  input  logic [2:0]    idx_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o,
  output logic          last_o
);
  localparam logic [AW-1:0] A_KEY_A = AW'(ADR_UNLK_A);
  localparam logic [AW-1:0] A_KEY_B = AW'(ADR_UNLK_B);

  always_comb begin
    addr_o = A_KEY_A;
    data_o = CMD_KEY_A;
    unique case (idx_i)
      3'd0: begin addr_o = A_KEY_A; data_o = CMD_KEY_A; end
      3'd1: begin addr_o = A_KEY_B; data_o = CMD_KEY_B; end
      3'd2: begin
        addr_o = A_KEY_A;
        data_o = (seq_i == SEQ_PROG) ? CMD_PROG :
                 (seq_i == SEQ_RST)  ? CMD_RESET : CMD_SETUP;
      end
      3'd3: begin
        addr_o = (seq_i == SEQ_PROG) ? addr_i : A_KEY_A;
        data_o = (seq_i == SEQ_PROG) ? data_i : CMD_KEY_A;
      end
      3'd4: begin addr_o = A_KEY_B; data_o = CMD_KEY_B; end
      default: begin
        addr_o = (seq_i == SEQ_CHIP) ? A_KEY_A : addr_i;
        data_o = (seq_i == SEQ_CHIP) ? CMD_CHIP : CMD_SECT;
      end
    endcase
  end

  assign last_o = ((seq_i == SEQ_PROG) && (idx_i == 3'd3)) ||
                  ((seq_i == SEQ_RST)  && (idx_i == 3'd2)) ||
                  (idx_i == 3'd5);
endmodule

// File: rtl/flash_status_eval.sv
module flash_status_eval
  import flash_pkg::*;
(
  input  logic       toggle_i,
  input  logic       recheck_i,
  input  logic       have_prev_i,
  input  logic       prev6_i,
  input  logic       exp7_i,
  input  logic [7:0] rdata_i,
  output verdict_e   verdict_o
);
  logic settled;

  always_comb begin
    settled = toggle_i ? (have_prev_i && (rdata_i[B_TOG] == prev6_i))
                       : (rdata_i[B_POLL] == exp7_i);
    if (settled)                                          verdict_o = V_PASS;
    else if (recheck_i)                                   verdict_o = V_FAIL;
    else if (rdata_i[B_ERR] && (!toggle_i || have_prev_i)) verdict_o = V_RECHK;
    else                                                  verdict_o = V_CONT;
  end
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (tick_i && !expire_o)  cnt_q <= cnt_q + 1'b1;
  end

  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r10_expire_after_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !expire_o) |=> (cnt_q != '0));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pkg::*;
#(
  parameter int AW         = 17,
  parameter int SECT_BITS  = 3,
  parameter int POLL_LIMIT = 4096
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [1:0]                req_op_i,
  input  logic [AW-1:0]             req_addr_i,
  input  logic [7:0]                req_data_i,
  input  logic [(1<<SECT_BITS)-1:0] req_sect_i,
  input  logic                      req_toggle_i,
  input  logic                      req_blank_i,
  output logic                      done_o,
  output logic                      pass_o,
  output logic                      warn_o,
  output logic                      mem_en_o,
  output logic                      mem_we_o,
  output logic [AW-1:0]             mem_addr_o,
  output logic [7:0]                mem_wdata_o,
  input  logic [7:0]                mem_rdata_i
);
  localparam int NSECT    = 1 << SECT_BITS;
  localparam int OFF_BITS = AW - SECT_BITS;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_XRD0, S_XEV0, S_XWR, S_XRD1, S_XEV1,
    S_PRD, S_PEV, S_VRD, S_VEV, S_DONE
  } state_e;

  state_e              state_q;
  seq_e                seq_q;
  logic [2:0]          idx_q;
  logic [AW-1:0]       addr_q, poll_addr_q;
  logic [7:0]          data_q;
  logic [NSECT-1:0]    rem_q;
  logic                exp7_q, toggle_q, blank_q, failed_q, warn_q;
  logic                have_prev_q, prev6_q, recheck_q;

  logic [SECT_BITS-1:0] req_low, rem_low;
  logic [AW-1:0]        rom_addr;
  logic [7:0]           rom_data;
  logic                 rom_last;
  verdict_e             verdict;
  logic                 accept, tick, expire;

  function automatic logic [AW-1:0] sect_base(input logic [SECT_BITS-1:0] s);
    return {s, {OFF_BITS{1'b0}}};
  endfunction

  always_comb begin
    req_low = '0;
    rem_low = '0;
    for (int i = NSECT - 1; i >= 0; i--) begin
      if (req_sect_i[i]) req_low = SECT_BITS'(i);
      if (rem_q[i])      rem_low = SECT_BITS'(i);
    end
  end

  flash_cmd_rom #(.AW(AW)) u_rom (
    .seq_i (seq_q), .idx_i (idx_q), .addr_i (addr_q), .data_i (data_q),
    .addr_o(rom_addr), .data_o(rom_data), .last_o(rom_last)
  );

  flash_status_eval u_eval (
    .toggle_i(toggle_q), .recheck_i(recheck_q), .have_prev_i(have_prev_q),
    .prev6_i(prev6_q), .exp7_i(exp7_q), .rdata_i(mem_rdata_i), .verdict_o(verdict)
  );

  assign accept = req_valid_i && (state_q == S_IDLE);
  assign tick   = (state_q == S_PEV) && (verdict == V_CONT);

  flash_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .tick_i(tick), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;  seq_q <= SEQ_PROG;  idx_q <= '0;
      addr_q <= '0;  poll_addr_q <= '0;  data_q <= '0;  rem_q <= '0;
      exp7_q <= 1'b0;  toggle_q <= 1'b0;  blank_q <= 1'b0;
      failed_q <= 1'b0;  warn_q <= 1'b0;
      have_prev_q <= 1'b0;  prev6_q <= 1'b0;  recheck_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          idx_q <= '0;  warn_q <= 1'b0;  failed_q <= 1'b0;
          have_prev_q <= 1'b0;  recheck_q <= 1'b0;
          toggle_q <= req_toggle_i;  blank_q <= req_blank_i;
          data_q <= req_data_i;  exp7_q <= 1'b1;  rem_q <= '0;
          unique case (op_e'(req_op_i))
            OP_PROG: begin
              seq_q <= SEQ_PROG;  addr_q <= req_addr_i;  poll_addr_q <= req_addr_i;
              exp7_q <= req_data_i[B_POLL];  blank_q <= 1'b0;  state_q <= S_CMD;
            end
            OP_SECT: begin
              if (req_sect_i == '0) begin
                failed_q <= 1'b1;  state_q <= S_DONE;
              end else begin
                seq_q <= SEQ_SECT;  addr_q <= sect_base(req_low);
                poll_addr_q <= sect_base(req_low);
                rem_q <= req_sect_i & ~(NSECT'(1) << req_low);
                state_q <= S_CMD;
              end
            end
            OP_CHIP: begin
              seq_q <= SEQ_CHIP;  poll_addr_q <= req_addr_i;  state_q <= S_CMD;
            end
            default: begin failed_q <= 1'b1;  state_q <= S_DONE; end
          endcase
        end
        S_CMD: begin
          idx_q <= idx_q + 3'd1;
          if (rom_last) begin
            idx_q <= '0;
            if (seq_q == SEQ_RST)                          state_q <= S_DONE;
            else if ((seq_q == SEQ_SECT) && (rem_q != '0)) state_q <= S_XRD0;
            else                                           state_q <= S_PRD;
          end
        end
        S_XRD0: state_q <= S_XEV0;
        S_XEV0: begin
          warn_q  <= warn_q | mem_rdata_i[B_TMR];
          state_q <= S_XWR;
        end
        S_XWR: begin
          rem_q   <= rem_q & ~(NSECT'(1) << rem_low);
          state_q <= S_XRD1;
        end
        S_XRD1: state_q <= S_XEV1;
        S_XEV1: begin
          warn_q  <= warn_q | mem_rdata_i[B_TMR];
          state_q <= (rem_q != '0) ? S_XRD0 : S_PRD;
        end
        S_PRD: state_q <= S_PEV;
        S_PEV: begin
          prev6_q     <= mem_rdata_i[B_TOG];
          have_prev_q <= 1'b1;
          unique case (verdict)
            V_PASS:  state_q <= blank_q ? S_VRD : S_DONE;
            V_RECHK: begin recheck_q <= 1'b1;  state_q <= S_PRD; end
            V_CONT:  if (expire) begin
                       failed_q <= 1'b1;  seq_q <= SEQ_RST;  idx_q <= '0;  state_q <= S_CMD;
                     end else state_q <= S_PRD;
            default: begin
              failed_q <= 1'b1;  seq_q <= SEQ_RST;  idx_q <= '0;  state_q <= S_CMD;
            end
          endcase
        end
        S_VRD: state_q <= S_VEV;
        S_VEV: begin
          if (mem_rdata_i == BLANK_BYTE) state_q <= S_DONE;
          else begin
            failed_q <= 1'b1;  seq_q <= SEQ_RST;  idx_q <= '0;  state_q <= S_CMD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_CMD: begin
        mem_en_o = 1'b1;  mem_we_o = 1'b1;  mem_addr_o = rom_addr;  mem_wdata_o = rom_data;
      end
      S_XWR: begin
        mem_en_o = 1'b1;  mem_we_o = 1'b1;  mem_addr_o = sect_base(rem_low);
        mem_wdata_o = CMD_SECT;
      end
      S_XRD0, S_XRD1, S_PRD, S_VRD: begin
        mem_en_o = 1'b1;  mem_addr_o = poll_addr_q;
      end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign pass_o      = done_o && !failed_q;
  assign warn_o      = warn_q;

  a_r11_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));
  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_en_o);
  a_r8_fail_ends_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o && $past(mem_we_o)) |-> ($past(mem_wdata_o) == CMD_RESET));
  a_r9_blank_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o && blank_q) |-> ($past(mem_rdata_i) == BLANK_BYTE));
endmodule

// File: tb/tb_flash_seq.sv
module tb_flash_seq;
  localparam int AW = 15;
  localparam int SB = 3;
  localparam int PL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_toggle = 1'b0, req_blank = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0, req_sect = '0;
  logic          req_ready, done, pass, warn;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = 8'h00;

  flash_seq #(.AW(AW), .SECT_BITS(SB), .POLL_LIMIT(PL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data), .req_sect_i(req_sect),
    .req_toggle_i(req_toggle), .req_blank_i(req_blank), .done_o(done), .pass_o(pass),
    .warn_o(warn), .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // scripted flash model
  logic          mdl_clr = 1'b0;
  int            m_busy = 0, m_d5 = 1000;
  logic          m_stuck = 1'b0, m_b7 = 1'b0;
  logic [7:0]    m_final = 8'hFF;
  logic [15:0]   m_d3 = '0;
  logic [AW-1:0] m_poll = '0;
  int            wn = 0, rn = 0, bad_raddr = 0, done_cnt = 0;
  logic          tog = 1'b0;
  logic [AW-1:0] wa [32];
  logic [7:0]    wd [32];

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (mdl_clr) begin
      wn <= 0;  rn <= 0;  tog <= 1'b0;  bad_raddr <= 0;
    end else if (mem_en) begin
      if (mem_we) begin
        if (wn < 32) begin wa[wn] <= mem_addr;  wd[wn] <= mem_wdata; end
        wn <= wn + 1;
      end else begin
        if (mem_addr != m_poll) bad_raddr <= bad_raddr + 1;
        if (m_stuck || rn < m_busy) begin
          mem_rdata <= {m_b7, tog, (rn >= m_d5), 1'b0, (rn < 16) ? m_d3[rn] : 1'b0, 3'b000};
          tog <= ~tog;
        end else mem_rdata <= m_final;
        rn <= rn + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] ea [32];
  logic [7:0]    ed [32];
  int            en = 0;
  logic          r_pass, r_warn;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
    ea[en] = a;  ed[en] = d;  en++;
  endtask

  task automatic exp_head(input logic [7:0] c);
    push(15'h5555, 8'hAA);  push(15'h2AAA, 8'h55);  push(15'h5555, c);
  endtask

  task automatic exp_erase(input bit chip, input logic [7:0] mask);
    exp_head(8'h80);
    push(15'h5555, 8'hAA);  push(15'h2AAA, 8'h55);
    if (chip) push(15'h5555, 8'h10);
    else for (int s = 0; s < 8; s++) if (mask[s]) push(AW'(s) << 12, 8'h30);
  endtask

  task automatic chk_writes(input string req);
    chk(wn == en, req, "write count", wn, en);
    for (int i = 0; i < en && i < wn; i++) begin
      chk(wa[i] == ea[i], req, "write addr", wa[i], ea[i]);
      chk(wd[i] == ed[i], req, "write data", wd[i], ed[i]);
    end
  endtask

  task automatic model(input int busy, input bit stuck, input int d5, input bit b7,
                       input logic [7:0] fin, input logic [15:0] d3, input logic [AW-1:0] poll);
    m_busy = busy;  m_stuck = stuck;  m_d5 = d5;  m_b7 = b7;
    m_final = fin;  m_d3 = d3;  m_poll = poll;  en = 0;
    @(negedge clk) mdl_clr = 1'b1;
    @(negedge clk) mdl_clr = 1'b0;
  endtask

  task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                     input logic [7:0] s, input bit tg, input bit bl, input int hold);
    int d0;
    d0 = done_cnt;
    @(negedge clk);
    req_op = op;  req_addr = a;  req_data = d;  req_sect = s;
    req_toggle = tg;  req_blank = bl;  req_valid = 1'b1;
    @(negedge clk);
    if (hold > 0) begin
      req_op = 2'b10;  req_sect = 8'hFF;  req_addr = 15'h0111;
      repeat (hold) @(negedge clk);
    end
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    r_pass = pass;  r_warn = warn;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after done", req_ready, 1);
    chk(done == 1'b0, "R11", "done one cycle", done, 0);
    chk(done_cnt - d0 == 1, "R11", "done count", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;  n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12", "ready", req_ready, 1);
    chk(done == 1'b0, "R12", "done", done, 0);
    chk(mem_en == 1'b0, "R12", "bus idle", mem_en, 0);

    // R1 / R2 program sweep over data values
    for (int v = 0; v < 256; v += 51) begin
      logic [AW-1:0] a;
      a = AW'(15'h0123 + v * 97);
      model(2, 0, 1000, ~v[7], 8'(v), '0, a);
      run(2'b00, a, 8'(v), 8'h00, 0, 0, 0);
      exp_head(8'hA0);  push(a, 8'(v));
      chk_writes("R1");
      chk(r_pass == 1'b1, "R2", "program pass", r_pass, 1);
      chk(rn == 3, "R2", "poll reads", rn, 3);
      chk(bad_raddr == 0, "R2", "poll address", bad_raddr, 0);
    end

    // R3 bit 5 then success on recheck
    model(2, 0, 1, 1'b1, 8'h11, '0, 15'h0400);
    run(2'b00, 15'h0400, 8'h11, 8'h00, 0, 0, 0);
    chk(r_pass == 1'b1, "R3", "recheck pass", r_pass, 1);
    chk(rn == 3, "R3", "recheck reads", rn, 3);

    // R3 / R8 bit 5 and no recovery
    model(0, 1, 0, 1'b1, 8'h11, '0, 15'h0400);
    run(2'b00, 15'h0400, 8'h11, 8'h00, 0, 0, 0);
    chk(r_pass == 1'b0, "R3", "recheck fail", r_pass, 0);
    chk(rn == 2, "R3", "fail reads", rn, 2);
    exp_head(8'hA0);  push(15'h0400, 8'h11);  exp_head(8'hF0);
    chk_writes("R8");

    // R4 toggle settles
    model(4, 0, 1000, 1'b0, 8'h00, '0, 15'h0044);
    run(2'b00, 15'h0044, 8'h00, 8'h00, 1, 0, 0);
    chk(r_pass == 1'b1, "R4", "toggle pass", r_pass, 1);
    chk(rn == 6, "R4", "toggle reads", rn, 6);

    // R4 toggle with bit 5 and no settle
    model(0, 1, 0, 1'b0, 8'h00, '0, 15'h0044);
    run(2'b00, 15'h0044, 8'h00, 8'h00, 1, 0, 0);
    chk(r_pass == 1'b0, "R4", "toggle fail", r_pass, 0);
    chk(rn == 3, "R4", "toggle fail reads", rn, 3);

    // R10 timeout
    model(0, 1, 1000, 1'b1, 8'h00, '0, 15'h0200);
    run(2'b00, 15'h0200, 8'h00, 8'h00, 0, 0, 0);
    chk(r_pass == 1'b0, "R10", "timeout fail", r_pass, 0);
    chk(rn == PL, "R10", "reads before timeout", rn, PL);
    exp_head(8'hA0);  push(15'h0200, 8'h00);  exp_head(8'hF0);
    chk_writes("R8");

    // R5 single sector
    model(2, 0, 1000, 1'b0, 8'hFF, '0, 15'h5000);
    run(2'b01, 15'h0000, 8'h00, 8'b0010_0000, 0, 0, 0);
    exp_erase(0, 8'b0010_0000);
    chk_writes("R5");
    chk(r_pass == 1'b1, "R5", "sector pass", r_pass, 1);
    chk(rn == 3 && bad_raddr == 0, "R5", "sector poll reads", rn, 3);

    // R6 extra sectors, timer clear
    model(6, 0, 1000, 1'b0, 8'hFF, 16'h0000, 15'h0000);
    run(2'b01, 15'h0000, 8'h00, 8'b1000_0101, 0, 0, 0);
    exp_erase(0, 8'b1000_0101);
    chk_writes("R6");
    chk(r_pass == 1'b1 && r_warn == 1'b0, "R6", "no warn", r_warn, 0);
    chk(rn == 7 && bad_raddr == 0, "R6", "reads", rn, 7);

    // R6 timer closed after second added sector
    model(6, 0, 1000, 1'b0, 8'hFF, 16'h0008, 15'h0000);
    run(2'b01, 15'h0000, 8'h00, 8'b1000_0101, 0, 0, 0);
    chk(r_warn == 1'b1, "R6", "warn", r_warn, 1);
    chk(r_pass == 1'b1, "R6", "pass with warn", r_pass, 1);

    // R7 / R9 chip erase with blank check
    model(1, 0, 1000, 1'b0, 8'hFF, '0, 15'h0777);
    run(2'b10, 15'h0777, 8'h00, 8'h00, 0, 1, 0);
    exp_erase(1, 8'h00);
    chk_writes("R7");
    chk(r_pass == 1'b1, "R9", "blank pass", r_pass, 1);
    chk(rn == 3 && bad_raddr == 0, "R9", "blank reads", rn, 3);

    model(1, 0, 1000, 1'b0, 8'hBF, '0, 15'h0777);
    run(2'b10, 15'h0777, 8'h00, 8'h00, 0, 1, 0);
    chk(r_pass == 1'b0, "R9", "blank fail", r_pass, 0);
    exp_erase(1, 8'h00);  exp_head(8'hF0);
    chk_writes("R8");

    // R13 refused requests
    model(0, 0, 1000, 1'b0, 8'hFF, '0, 15'h0000);
    run(2'b01, 15'h0000, 8'h00, 8'h00, 0, 0, 0);
    chk(r_pass == 1'b0, "R13", "empty mask fails", r_pass, 0);
    chk(wn == 0 && rn == 0, "R13", "no bus", wn + rn, 0);
    model(0, 0, 1000, 1'b0, 8'hFF, '0, 15'h0000);
    run(2'b11, 15'h0000, 8'h00, 8'h00, 0, 0, 0);
    chk(r_pass == 1'b0, "R13", "reserved fails", r_pass, 0);
    chk(wn == 0 && rn == 0, "R13", "reserved no bus", wn + rn, 0);

    // R11 request while busy is ignored
    model(2, 0, 1000, 1'b1, 8'h80, '0, 15'h0333);
    run(2'b00, 15'h0333, 8'h80, 8'h00, 0, 0, 3);
    exp_head(8'hA0);  push(15'h0333, 8'h80);
    chk_writes("R11");
    chk(r_pass == 1'b1, "R11", "busy request ignored", r_pass, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule